// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This block holds the one-byte status register of a serial memory and decides, cycle by cycle, whether an array write or a status write may go ahead. It owns a write-enable latch, two block-protect bits that fence off the top part of the address space, and a protect-enable bit. The protect-enable bit works together with an active-low external protect pin to lock the status register. A busy indication from the engine's write timer appears in the status byte but cannot be written.

The serial engine decodes commands and presents them as single-cycle strobes. These are set-latch, clear-latch, status write with its data byte, and array write with its target address. The allow outputs are combinational, so the engine can use them in the same cycle as the request. When a strobe is allowed, its effect on the registered bits shows up in the status byte after the next clock edge. When a write is denied, it leaves every stored bit unchanged.

Top module: `sr_protect_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, the status byte equals 0x00 with busy low, and both allow outputs are 0.
- R2: A set-latch strobe makes status bit 1 read 1 after the next clock edge. A clear-latch strobe makes it read 0. Both work whatever the pin level and the protect-enable bit.
- R3: Status layout: bit 7 is protect-enable, bits 6 to 4 always read 0, bits 3:2 are the block-protect code, bit 1 is the write-enable latch, and bit 0 follows `busy_i` in the same cycle.
- R4: An allowed status write loads data bit 7 into protect-enable and data bits 3:2 into the block-protect code, and clears the latch. Data bits 6:4, 1 and 0 have no effect.
- R5: `sts_allow_o` is 1 exactly when the latch is 1 and either protect-enable is 0 or `wp_n_i` is 1. A denied status write changes no stored bit.
- R6: `arr_allow_o` is 1 exactly when the latch is 1 and the address lies outside the protected range. The pin level has no effect on it.
- R7: Block-protect code 00 protects nothing, 01 protects 0xC00 to 0xFFF, 10 protects 0x800 to 0xFFF, and 11 protects every address (12-bit address). In general the code looks at the top two address bits.
- R8: An allowed array write clears the latch after the next edge. A denied array write leaves it unchanged.
- R9: When a set strobe and any clearing event fall in the same cycle, the latch ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_wel_i | input | 1 | Set-latch command strobe |
| clr_wel_i | input | 1 | Clear-latch command strobe |
| sts_wr_i | input | 1 | Status write command strobe |
| sts_data_i | input | 8 | Data byte for a status write |
| arr_wr_i | input | 1 | Array write command strobe |
| arr_addr_i | input | ADDR_W | Array write target address |
| wp_n_i | input | 1 | Protect pin, low asserts hardware lock |
| busy_i | input | 1 | Write timer busy indication |
| status_o | output | 8 | Status byte |
| sts_allow_o | output | 1 | Status write permitted |
| arr_allow_o | output | 1 | Array write permitted at `arr_addr_i` |

## Verification
The bench probes the range edges at 0xBFF/0xC00 and 0x7FF/0x800, and the all-protected code at address 0. A wrong range decode would grant a write into a fenced quarter or refuse one just below it. It drives the pin low with protect-enable set and checks that the status write is refused while array writes and the latch commands still work. A design that tied the pin to the array path or to the latch commands would show up as a wrong allow bit or a stuck latch. Simultaneous set and clear strobes, writes attempted with the latch low, and status data with the unused bits set are also covered. Each of these catches, in turn, a set-over-clear priority, a latch cleared by a denied write, and junk leaking into bits 6 to 4.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int STS_W   = 8;
    localparam int B_WPEN  = 7;
    localparam int B_BPHI  = 3;
    localparam int B_BPLO  = 2;
    localparam int B_WEL   = 1;
    localparam int B_BUSY  = 0;

    typedef enum logic [1:0] {
        BP_NONE = 2'b00,
        BP_QTR  = 2'b01,
        BP_HALF = 2'b10,
        BP_ALL  = 2'b11
    } bp_t;

    typedef struct packed {
        logic wpen;
        bp_t  bp;
    } nv_t;

    // Top two address bits against the block-protect code.
    function automatic logic addr_fenced(input logic [1:0] top2, input bp_t bp);
        case (bp)
            BP_NONE: return 1'b0;
            BP_QTR:  return (top2 == 2'b11);
            BP_HALF: return top2[1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [STS_W-1:0] pack_status(input nv_t nv, input logic wel,
                                                     input logic busy);
        logic [STS_W-1:0] s;
        s          = '0;
        s[B_WPEN]  = nv.wpen;
        s[B_BPHI:B_BPLO] = nv.bp;
        s[B_WEL]   = wel;
        s[B_BUSY]  = busy;
        return s;
    endfunction

endpackage

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    always_ff @(posedge clk) begin
        if (rst)        wel_o <= 1'b0;
        else if (clr_i) wel_o <= 1'b0;   // clearing wins (R9)
        else if (set_i) wel_o <= 1'b1;
    end
endmodule

// File: rtl/sr_nv_bits.sv
module sr_nv_bits
    import sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [STS_W-1:0] data_i,
    output nv_t              nv_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nv_o.wpen <= 1'b0;
            nv_o.bp   <= BP_NONE;
        end else if (load_i) begin
            nv_o.wpen <= data_i[B_WPEN];
            nv_o.bp   <= bp_t'(data_i[B_BPHI:B_BPLO]);
        end
    end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_pkg::*;
(
    input  logic       wel_i,
    input  nv_t        nv_i,
    input  logic       wp_n_i,
    input  logic [1:0] addr_top_i,
    output logic       sts_ok_o,
    output logic       arr_ok_o
);
    logic hw_lock;

    always_comb begin
        hw_lock  = nv_i.wpen && !wp_n_i;
        sts_ok_o = wel_i && !hw_lock;
        arr_ok_o = wel_i && !addr_fenced(addr_top_i, nv_i.bp);
    end
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
    import sr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              sts_wr_i,
    input  logic [STS_W-1:0]  sts_data_i,
    input  logic              arr_wr_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              wp_n_i,
    input  logic              busy_i,
    output logic [STS_W-1:0]  status_o,
    output logic              sts_allow_o,
    output logic              arr_allow_o
);
    localparam int TOP_LO = ADDR_W - 2;

    logic       wel;
    nv_t        nv;
    logic       sts_take;
    logic       arr_take;
    logic       wel_clr;
    logic [1:0] addr_top;

    assign addr_top = arr_addr_i[ADDR_W-1:TOP_LO];

    sr_guard u_guard (
        .wel_i      (wel),
        .nv_i       (nv),
        .wp_n_i     (wp_n_i),
        .addr_top_i (addr_top),
        .sts_ok_o   (sts_allow_o),
        .arr_ok_o   (arr_allow_o)
    );

    assign sts_take = sts_wr_i && sts_allow_o;
    assign arr_take = arr_wr_i && arr_allow_o;
    assign wel_clr  = clr_wel_i || sts_take || arr_take;

    sr_wel_latch u_wel (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_wel_i),
        .clr_i (wel_clr),
        .wel_o (wel)
    );

    sr_nv_bits u_nv (
        .clk    (clk),
        .rst    (rst),
        .load_i (sts_take),
        .data_i (sts_data_i),
        .nv_o   (nv)
    );

    assign status_o = pack_status(nv, wel, busy_i);

    // R8: a granted array write drops the latch
    assert_arr_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (arr_wr_i && arr_allow_o) |=> !status_o[B_WEL]);

    // R5: a refused status write keeps the stored protection bits
    assert_sts_denied_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (sts_wr_i && !sts_allow_o) |=> $stable(status_o[B_WPEN:B_BPLO]));

    // R5: pin low with protect-enable set locks the status register
    assert_hw_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (status_o[B_WPEN] && !wp_n_i) |-> !sts_allow_o);

    // R6: no grant without the latch
    assert_grant_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
        (arr_allow_o || sts_allow_o) |-> status_o[B_WEL]);

    // R7: the all-protected code refuses every address
    assert_all_fenced_R7: assert property (@(posedge clk) disable iff (rst)
        (status_o[B_BPHI:B_BPLO] == 2'b11) |-> !arr_allow_o);

    // R2: a lone set strobe raises the latch
    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (set_wel_i && !clr_wel_i && !sts_wr_i && !arr_wr_i) |=> status_o[B_WEL]);

    // R2: a clear strobe always drops the latch
    assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
        clr_wel_i |=> !status_o[B_WEL]);

endmodule

// File: tb/test_sr_protect_unit.sv
module test_sr_protect_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_wel = 0, clr_wel = 0, sts_wr = 0, arr_wr = 0;
    logic [7:0]    sts_data = '0;
    logic [AW-1:0] arr_addr = '0;
    logic          wp_n = 1'b1, busy = 1'b0;
    logic [7:0]    status;
    logic          sts_allow, arr_allow;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_protect_unit #(.ADDR_W(AW)) i_sr_protect_unit (
        .clk(clk), .rst(rst),
        .set_wel_i(set_wel), .clr_wel_i(clr_wel),
        .sts_wr_i(sts_wr), .sts_data_i(sts_data),
        .arr_wr_i(arr_wr), .arr_addr_i(arr_addr),
        .wp_n_i(wp_n), .busy_i(busy),
        .status_o(status), .sts_allow_o(sts_allow), .arr_allow_o(arr_allow)
    );

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic       sa;
        logic       aa;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference state, built from the requirements
    logic       m_wel = 0, m_wpen = 0;
    logic [1:0] m_bp = 0;

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "status", status, e.st);
                cmp(e.tag, "sts_allow", {7'd0, sts_allow}, {7'd0, e.sa});
                cmp(e.tag, "arr_allow", {7'd0, arr_allow}, {7'd0, e.aa});
            end
        end
    end

    function automatic logic fenced(logic [AW-1:0] a, logic [1:0] bp);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 12'hC00;
            2'b10:   return a >= 12'h800;
            default: return 1'b1;
        endcase
    endfunction

    // driver: one cycle of stimulus, expectation pushed, reference advanced
    task automatic step(string tag, bit s, bit c, bit sw, logic [7:0] d,
                        bit aw, logic [AW-1:0] a, bit wp, bit bz);
        exp_t e;
        @(posedge clk); #1;
        set_wel = s; clr_wel = c; sts_wr = sw; sts_data = d;
        arr_wr = aw; arr_addr = a; wp_n = wp; busy = bz;
        e.tag = tag;
        e.st  = {m_wpen, 3'b000, m_bp, m_wel, bz};
        e.sa  = m_wel && (!m_wpen || wp);
        e.aa  = m_wel && !fenced(a, m_bp);
        q.push_back(e);
        if (c) m_wel = 0;
        else if (sw && e.sa) begin
            m_wpen = d[7]; m_bp = d[3:2]; m_wel = 0;
        end else if (aw && e.aa) m_wel = 0;
        else if (s) m_wel = 1;
    endtask

    task automatic idle(string tag, logic [AW-1:0] a, bit wp);
        step(tag, 0, 0, 0, 8'h00, 0, a, wp, 0);
    endtask

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        #1;
        e.tag = "R1 in reset"; e.st = 8'h00; e.sa = 0; e.aa = 0;
        q.push_back(e);
        @(posedge clk); #1 rst = 0;
        idle("R1 after reset", 12'h000, 1);
        step("R8 denied array write, latch low", 0,0,0,8'h00, 1,12'h000, 1,0);
        idle("R8 latch stays low", 12'h000, 1);
        step("R2 set latch", 1,0,0,8'h00, 0,12'h000, 1,0);
        step("R3 busy bit follows", 0,0,0,8'h00, 0,12'h100, 1,1);
        step("R8 allowed array write", 0,0,0,8'h00, 1,12'h100, 1,0);
        idle("R8 latch cleared", 12'h100, 1);
        step("R2 set latch", 1,0,0,8'h00, 0,12'h000, 1,0);
        step("R4 status write all ones", 0,0,1,8'hFF, 0,12'h000, 1,0);
        idle("R4 bits 7,3,2 loaded", 12'h000, 1);
        step("R2 set latch pin low", 1,0,0,8'h00, 0,12'h000, 0,0);
        step("R5 status write refused, pin low", 0,0,1,8'h00, 0,12'h000, 0,0);
        idle("R7 code 11 fences address 0", 12'h000, 0);
        step("R5 status write with pin high", 0,0,1,8'h84, 0,12'h000, 1,0);
        step("R2 set latch pin low", 1,0,0,8'h00, 0,12'h000, 0,0);
        idle("R7 R6 quarter 0xBFF open pin low", 12'hBFF, 0);
        idle("R7 quarter 0xC00 fenced", 12'hC00, 0);
        step("R5 refused write keeps bits", 0,0,1,8'h0C, 0,12'h000, 0,0);
        step("R2 clear latch pin low", 0,1,0,8'h00, 0,12'h000, 0,0);
        step("R2 set latch pin low", 1,0,0,8'h00, 0,12'h000, 0,0);
        step("R4 status write code 10", 0,0,1,8'h08, 0,12'h000, 1,0);
        step("R2 set latch", 1,0,0,8'h00, 0,12'h000, 1,0);
        idle("R7 half 0x7FF open", 12'h7FF, 1);
        idle("R7 half 0x800 fenced", 12'h800, 0);
        step("R8 denied array write keeps latch", 0,0,0,8'h00, 1,12'hFFF, 1,0);
        step("R9 set and clear together", 1,1,0,8'h00, 0,12'h000, 1,0);
        idle("R9 latch low", 12'h000, 1);
        step("R2 set latch", 1,0,0,8'h00, 0,12'h000, 1,0);
        step("R9 set with allowed array write", 1,0,0,8'h00, 1,12'h000, 1,0);
        step("R2 set latch", 1,0,0,8'h00, 0,12'h000, 1,0);
        step("R4 unused data bits ignored", 0,0,1,8'h73, 0,12'h000, 1,0);
        step("R2 set latch", 1,0,0,8'h00, 0,12'h000, 1,0);
        idle("R7 code 00 top address open", 12'hFFF, 0);
        idle("R3 final status", 12'hFFF, 1);
        @(posedge clk); #1;
        set_wel = 0; sts_wr = 0; arr_wr = 0; clr_wel = 0;
        @(negedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule